// File: doc/BRIEF.md
# Serial audio input receiver

This block turns stereo serial audio into parallel left and right sample words. It has several input ports, and each port works on its own. Every port has its own data line and its own external bit clock and channel clock pins. All ports share an on-chip set of clocks: a channel clock, a 32 fs bit clock and a 64 fs bit clock. Four static configuration bits per port set the behaviour:
- which channel clock the port follows;
- which bit clock it follows;
- the word length, 16 or 24 bits;
- the bit order.

All clock and data pins are asynchronous to the system clock. Each one passes through a flip-flop synchronizer, and the block then finds bit clock edges by comparing each sample against the previous one. The port captures one data bit at every rising edge of its selected bit clock. A change in the channel clock level marks a word boundary. The bits that arrived just before that boundary make up the word, so the data is right-justified. This means a 24-bit word works with 48 fs and 64 fs bit clocks, and no slot counting is needed.

Completed stereo pairs leave through a valid/ready stream, one per port. A pair waits in an output register until the consumer accepts it. The serial side cannot be stalled. If a newer pair completes while one is still waiting, the newer pair replaces it and valid stays high. The block never drops the newest pair.

Top module: `sair_rx_top`

## Requirements
- R1: With `cfg_lr_ext[p]`=0, port p follows the shared on-chip channel clock `int_lr`. With `cfg_lr_ext[p]`=1, it follows its own pin `ext_lr[p]`. The clock that is not selected has no effect.
- R2: With `cfg_bclk_ext[p]`=1, port p captures on its own pin `ext_bclk[p]`. With `cfg_bclk_ext[p]`=0, it captures on `int_bclk32` in 16-bit mode and on `int_bclk64` in 24-bit mode. A bit clock that is not selected captures nothing.
- R3: A data bit and the channel clock level are both taken at each rising edge of the selected bit clock. A high level means left and a low level means right. When the level taken differs from the previous one, that edge starts a new half-period, and the bit taken at that edge belongs to the new half.
- R4: In 16-bit mode (`cfg_wide[p]`=0), the word is the last 16 bits before the boundary. It appears on sample bits [23:8], and bits [7:0] are zero.
- R5: In 24-bit mode (`cfg_wide[p]`=1), the word is the last 24 bits before the boundary, and any earlier slots in that half are ignored. This works with 24 and 32 slots per half-period, which are the 48 fs and 64 fs bit clocks.
- R6: With `cfg_lsb_first[p]`=0, the first bit of the word is its MSB. With `cfg_lsb_first[p]`=1, the first bit of the word is its LSB.
- R7: A pair is delivered only when a left word completes and then a right word completes. The right word completes at the boundary from right to left. A right word with no left word before it is discarded.
- R8: Once `out_valid[p]` is high, it stays high until `out_ready[p]` is high. While the pair waits, the sample outputs do not change unless a newer pair completes, and the newer pair then replaces it. After a pair is accepted and no new pair arrives, valid goes low on the next cycle.
- R9: The ports are independent. Activity on one port produces no output on another port.
- R10: After reset, `out_valid` is low and the sample outputs are zero. Changing any configuration bit of a port discards that port's partial word and any pending left word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_lr | input | 1 | Shared on-chip channel clock |
| int_bclk32 | input | 1 | Shared on-chip 32 fs bit clock |
| int_bclk64 | input | 1 | Shared on-chip 64 fs bit clock |
| ext_lr | input | NUM_PORTS | External channel clock, one per port |
| ext_bclk | input | NUM_PORTS | External bit clock, one per port |
| sdata | input | NUM_PORTS | Serial data, one per port |
| cfg_lr_ext | input | NUM_PORTS | Channel clock source select per port |
| cfg_bclk_ext | input | NUM_PORTS | Bit clock source select per port |
| cfg_wide | input | NUM_PORTS | 1 selects 24-bit words, 0 selects 16-bit words |
| cfg_lsb_first | input | NUM_PORTS | 1 selects LSB-first bit order |
| out_ready | input | NUM_PORTS | Consumer ready per port |
| out_valid | output | NUM_PORTS | Stereo pair valid per port |
| out_left | output | NUM_PORTS*SAMPLE_W | Left samples, port p in slice p |
| out_right | output | NUM_PORTS*SAMPLE_W | Right samples, port p in slice p |

## Verification
The bench builds the block with its default parameters:
- NUM_PORTS=2 lets one port run while the other is configured but idle, which exercises isolation between ports.
- SAMPLE_W=24 and SHORT_W=16 put both word lengths and both justifications in reach: 16-bit MSB-aligned words, and 24-bit words with 32 slots (8 leading slots ignored) and with 24 slots.
- SYNC_STAGES=2 keeps the path from pin to output short.

Because of these settings, the bench can cover every combination of clock source with each bit order, a full stall with replacement of the waiting pair, and a configuration change in the middle of a frame.

// File: rtl/sair_pkg.sv
package sair_pkg;
  typedef struct packed {
    logic lr_ext;
    logic bclk_ext;
    logic wide;
    logic lsb_first;
  } sair_mode_t;
endpackage

// File: rtl/sair_sync.sv
module sair_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sair_clksel.sv
module sair_clksel
  import sair_pkg::*;
(
  input  sair_mode_t mode,
  input  logic       int_lr_s,
  input  logic       int_b32_s,
  input  logic       int_b64_s,
  input  logic       ext_lr_s,
  input  logic       ext_bclk_s,
  output logic       lr_sel,
  output logic       bclk_sel
);
  always_comb begin
    lr_sel = mode.lr_ext ? ext_lr_s : int_lr_s;
    if (mode.bclk_ext)  bclk_sel = ext_bclk_s;
    else if (mode.wide) bclk_sel = int_b64_s;
    else                bclk_sel = int_b32_s;
  end
endmodule

// File: rtl/sair_lane.sv
module sair_lane
  import sair_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sair_mode_t          mode,
  input  logic                bclk_s,
  input  logic                lr_s,
  input  logic                data_s,
  output logic                pair_stb,
  output logic [SAMPLE_W-1:0] left_word,
  output logic [SAMPLE_W-1:0] right_word
);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  logic                bclk_q;
  logic                rise;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shreg_rev;
  logic [SAMPLE_W-1:0] word;
  logic                lr_last;
  logic                primed;
  logic                have_left;
  sair_mode_t          mode_q;
  logic                mode_chg;

  assign rise     = bclk_s & ~bclk_q;
  assign mode_chg = (mode != mode_q);

  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++) shreg_rev[i] = shreg[SAMPLE_W-1-i];
  end

  // Word extraction: the newest bits sit at the low end of shreg.
  always_comb begin
    if (mode.wide) begin
      word = mode.lsb_first ? shreg_rev : shreg;
    end else if (mode.lsb_first) begin
      word = {shreg_rev[SAMPLE_W-1:PAD_W], {PAD_W{1'b0}}};
    end else begin
      word = {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      shreg      <= '0;
      lr_last    <= 1'b0;
      primed     <= 1'b0;
      have_left  <= 1'b0;
      mode_q     <= '0;
      pair_stb   <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
    end else begin
      bclk_q   <= bclk_s;
      mode_q   <= mode;
      pair_stb <= 1'b0;
      if (mode_chg) begin
        primed    <= 1'b0;
        have_left <= 1'b0;
        shreg     <= '0;
      end else if (rise) begin
        shreg   <= {shreg[SAMPLE_W-2:0], data_s};
        lr_last <= lr_s;
        primed  <= 1'b1;
        if (primed && (lr_s != lr_last)) begin
          if (lr_last) begin
            left_word <= word;
            have_left <= 1'b1;
          end else begin
            if (have_left) begin
              right_word <= word;
              pair_stb   <= 1'b1;
            end
            have_left <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sair_hold.sv
module sair_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_stb,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                ready,
  output logic                valid,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
    end else if (pair_stb) begin
      valid     <= 1'b1;
      left_out  <= left_in;
      right_out <= right_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sair_rx_top.sv
module sair_rx_top
  import sair_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          int_lr,
  input  logic                          int_bclk32,
  input  logic                          int_bclk64,
  input  logic [NUM_PORTS-1:0]          ext_lr,
  input  logic [NUM_PORTS-1:0]          ext_bclk,
  input  logic [NUM_PORTS-1:0]          sdata,
  input  logic [NUM_PORTS-1:0]          cfg_lr_ext,
  input  logic [NUM_PORTS-1:0]          cfg_bclk_ext,
  input  logic [NUM_PORTS-1:0]          cfg_wide,
  input  logic [NUM_PORTS-1:0]          cfg_lsb_first,
  input  logic [NUM_PORTS-1:0]          out_ready,
  output logic [NUM_PORTS-1:0]          out_valid,
  output logic [NUM_PORTS*SAMPLE_W-1:0] out_left,
  output logic [NUM_PORTS*SAMPLE_W-1:0] out_right
);
  logic [2:0]           int_s;
  logic [NUM_PORTS-1:0] pair_stb;

  sair_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync_int (
    .clk (clk),
    .rst_n (rst_n),
    .d ({int_lr, int_bclk32, int_bclk64}),
    .q (int_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [2:0]          pin_s;
    sair_mode_t          mode;
    logic                lr_sel;
    logic                bclk_sel;
    logic [SAMPLE_W-1:0] lw;
    logic [SAMPLE_W-1:0] rw;

    assign mode = '{lr_ext: cfg_lr_ext[p], bclk_ext: cfg_bclk_ext[p],
                    wide: cfg_wide[p], lsb_first: cfg_lsb_first[p]};

    sair_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync_pin (
      .clk (clk),
      .rst_n (rst_n),
      .d ({ext_lr[p], ext_bclk[p], sdata[p]}),
      .q (pin_s)
    );

    sair_clksel i_clksel (
      .mode (mode),
      .int_lr_s (int_s[2]),
      .int_b32_s (int_s[1]),
      .int_b64_s (int_s[0]),
      .ext_lr_s (pin_s[2]),
      .ext_bclk_s (pin_s[1]),
      .lr_sel (lr_sel),
      .bclk_sel (bclk_sel)
    );

    sair_lane #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) i_lane (
      .clk (clk),
      .rst_n (rst_n),
      .mode (mode),
      .bclk_s (bclk_sel),
      .lr_s (lr_sel),
      .data_s (pin_s[0]),
      .pair_stb (pair_stb[p]),
      .left_word (lw),
      .right_word (rw)
    );

    sair_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
      .clk (clk),
      .rst_n (rst_n),
      .pair_stb (pair_stb[p]),
      .left_in (lw),
      .right_in (rw),
      .ready (out_ready[p]),
      .valid (out_valid[p]),
      .left_out (out_left[p*SAMPLE_W +: SAMPLE_W]),
      .right_out (out_right[p*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/sair_rx_checker.sv
module sair_rx_checker #(
  parameter int NUM_PORTS = 2,
  parameter int SAMPLE_W  = 24
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_PORTS-1:0]          pair_stb,
  input logic [NUM_PORTS-1:0]          out_valid,
  input logic [NUM_PORTS-1:0]          out_ready,
  input logic [NUM_PORTS*SAMPLE_W-1:0] out_left,
  input logic [NUM_PORTS*SAMPLE_W-1:0] out_right
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] && !out_ready[p] |=> out_valid[p]);

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] && !out_ready[p] && !pair_stb[p] |=>
        $stable(out_left[p*SAMPLE_W +: SAMPLE_W]) &&
        $stable(out_right[p*SAMPLE_W +: SAMPLE_W]));

    p_drop_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] && out_ready[p] && !pair_stb[p] |=> !out_valid[p]);

    p_valid_from_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[p]) |-> $past(pair_stb[p]));

    p_single_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pair_stb[p] |=> !pair_stb[p]);
  end
endmodule

bind sair_rx_top sair_rx_checker #(.NUM_PORTS(NUM_PORTS), .SAMPLE_W(SAMPLE_W)) i_chk (
  .clk (clk),
  .rst_n (rst_n),
  .pair_stb (pair_stb),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left (out_left),
  .out_right (out_right)
);

// File: tb/test_sair_rx_top.sv
module test_sair_rx_top;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_lr = 1'b0, int_bclk32 = 1'b0, int_bclk64 = 1'b0;
  logic [1:0] ext_lr = '0, ext_bclk = '0, sdata = '0;
  logic [1:0] cfg_lr_ext = '0, cfg_bclk_ext = '0, cfg_wide = '0, cfg_lsb_first = '0;
  logic [1:0] out_ready = 2'b11;
  logic [1:0] out_valid;
  logic [47:0] out_left, out_right;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int acc_cnt [2];
  logic [23:0] acc_l [2];
  logic [23:0] acc_r [2];

  always #5 clk = ~clk;

  sair_rx_top i_sair_rx_top (
    .clk (clk), .rst_n (rst_n),
    .int_lr (int_lr), .int_bclk32 (int_bclk32), .int_bclk64 (int_bclk64),
    .ext_lr (ext_lr), .ext_bclk (ext_bclk), .sdata (sdata),
    .cfg_lr_ext (cfg_lr_ext), .cfg_bclk_ext (cfg_bclk_ext),
    .cfg_wide (cfg_wide), .cfg_lsb_first (cfg_lsb_first),
    .out_ready (out_ready), .out_valid (out_valid),
    .out_left (out_left), .out_right (out_right)
  );

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (rst_n && out_valid[p] && out_ready[p]) begin
        acc_cnt[p] = acc_cnt[p] + 1;
        acc_l[p] = out_left[p*24 +: 24];
        acc_r[p] = out_right[p*24 +: 24];
      end
    end
  end

  // mode nibble: {lr_ext, bclk_ext, wide, lsb_first}; slots; left; right
  localparam int NV = 9;
  localparam logic [63:0] VECS [NV] = '{
    {4'b0000, 4'h0, 8'd16, 24'h00A55A, 24'h003C0F},  // R1 R2 R4 internal, MSB first
    {4'b0001, 4'h0, 8'd16, 24'h001234, 24'h00F00D},  // R6 LSB first 16-bit
    {4'b0010, 4'h0, 8'd32, 24'h123456, 24'hABCDEF},  // R5 64 fs internal
    {4'b0011, 4'h0, 8'd32, 24'h800001, 24'h7F00FE},  // R5 R6
    {4'b1110, 4'h0, 8'd24, 24'hC0FFEE, 24'h135799},  // R5 48 fs external
    {4'b1111, 4'h0, 8'd24, 24'h0F1E2D, 24'hF0E1D2},  // R6
    {4'b1100, 4'h0, 8'd16, 24'h00BEEF, 24'h00CAFE},  // R1 R2 external
    {4'b0110, 4'h0, 8'd32, 24'h5A5A5A, 24'h010203},  // mixed sources
    {4'b1001, 4'h0, 8'd16, 24'h00FACE, 24'h000001}   // mixed sources
  };

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [23:0] w, input logic wide);
    return wide ? w : {w[15:0], 8'h00};
  endfunction

  task automatic set_cfg(input int p, input logic [3:0] m);
    @(negedge clk);
    cfg_lr_ext[p] = m[3]; cfg_bclk_ext[p] = m[2]; cfg_wide[p] = m[1]; cfg_lsb_first[p] = m[0];
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_half(input int p, input logic [3:0] m, input logic lvl,
                            input int slots, input logic [23:0] w);
    int nb;
    nb = m[1] ? 24 : 16;
    for (int s = 0; s < slots; s++) begin
      logic b;
      if (s < slots - nb) b = 1'b1;
      else if (m[0]) b = w[s - (slots - nb)];
      else b = w[nb - 1 - (s - (slots - nb))];
      @(negedge clk);
      if (m[3]) begin ext_lr[p] = lvl; int_lr = ~lvl; end
      else begin int_lr = lvl; ext_lr[p] = ~lvl; end
      sdata[p] = b;
      ext_bclk[p] = 1'b0; int_bclk32 = 1'b0; int_bclk64 = 1'b0;
      repeat (H) @(negedge clk);
      if (m[2]) ext_bclk[p] = 1'b1;
      else if (m[1]) int_bclk64 = 1'b1;
      else int_bclk32 = 1'b1;
      repeat (H - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    acc_cnt[0] = 0; acc_cnt[1] = 0;
    acc_l[0] = '0; acc_l[1] = '0; acc_r[0] = '0; acc_r[1] = '0;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(out_valid == 2'b00, "R10 reset valid", {46'd0, out_valid}, 48'd0);
    check(out_left == '0 && out_right == '0, "R10 reset samples", out_left, 48'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] m;
      int sl;
      logic [23:0] l, r;
      m = VECS[v][63:60]; sl = int'(VECS[v][55:48]); l = VECS[v][47:24]; r = VECS[v][23:0];
      set_cfg(0, m);
      acc_cnt[0] = 0;
      drive_half(0, m, 1'b0, sl, 24'h5A33C6);
      drive_half(0, m, 1'b1, sl, l);
      drive_half(0, m, 1'b0, sl, r);
      drive_half(0, m, 1'b1, sl, 24'hE1E1E1);
      repeat (10) @(negedge clk);
      check(acc_cnt[0] == 1, "R7 R3 one pair per frame", 48'(acc_cnt[0]), 48'd1);
      check(acc_l[0] == exp_word(l, m[1]), "R1 R2 R4 R5 R6 left word", {24'd0, acc_l[0]}, {24'd0, exp_word(l, m[1])});
      check(acc_r[0] == exp_word(r, m[1]), "R1 R2 R4 R5 R6 right word", {24'd0, acc_r[0]}, {24'd0, exp_word(r, m[1])});
    end

    // R8: back-pressure, newest pair replaces the waiting one
    begin
      logic [3:0] m;
      m = 4'b0010;
      set_cfg(0, m);
      out_ready[0] = 1'b0;
      acc_cnt[0] = 0;
      drive_half(0, m, 1'b0, 32, 24'h000000);
      drive_half(0, m, 1'b1, 32, 24'h111111);
      drive_half(0, m, 1'b0, 32, 24'h222222);
      drive_half(0, m, 1'b1, 32, 24'h333333);
      drive_half(0, m, 1'b0, 32, 24'h444444);
      drive_half(0, m, 1'b1, 32, 24'h999999);
      repeat (10) @(negedge clk);
      check(out_valid[0] == 1'b1, "R8 valid held", {47'd0, out_valid[0]}, 48'd1);
      check(out_left[23:0] == 24'h333333 && out_right[23:0] == 24'h444444,
            "R8 newest pair kept", {out_left[23:0], out_right[23:0]}, {24'h333333, 24'h444444});
      @(posedge clk); #1 out_ready[0] = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid[0] == 1'b0, "R8 valid drops after accept", {47'd0, out_valid[0]}, 48'd0);
      check(acc_cnt[0] == 1, "R8 exactly one accept", 48'(acc_cnt[0]), 48'd1);
    end

    // R9: port 1 active, port 0 configured external but idle
    begin
      logic [3:0] m;
      m = 4'b1110;
      set_cfg(0, 4'b1100);
      set_cfg(1, m);
      acc_cnt[0] = 0; acc_cnt[1] = 0;
      drive_half(1, m, 1'b0, 24, 24'h0);
      drive_half(1, m, 1'b1, 24, 24'h6B6B6B);
      drive_half(1, m, 1'b0, 24, 24'h2468AC);
      drive_half(1, m, 1'b1, 24, 24'h0);
      repeat (10) @(negedge clk);
      check(acc_cnt[1] == 1 && acc_l[1] == 24'h6B6B6B && acc_r[1] == 24'h2468AC,
            "R9 port 1 pair", {acc_l[1], acc_r[1]}, {24'h6B6B6B, 24'h2468AC});
      check(acc_cnt[0] == 0, "R9 port 0 silent", 48'(acc_cnt[0]), 48'd0);
    end

    // R10 R7: configuration change mid-frame discards the pending left word
    begin
      set_cfg(0, 4'b0000);
      acc_cnt[0] = 0;
      drive_half(0, 4'b0000, 1'b0, 16, 24'h000F0F);
      drive_half(0, 4'b0000, 1'b1, 16, 24'h00ABCD);
      drive_half(0, 4'b0000, 1'b0, 4, 24'h000000);
      set_cfg(0, 4'b0001);
      drive_half(0, 4'b0001, 1'b0, 16, 24'h001111);
      drive_half(0, 4'b0001, 1'b1, 16, 24'h002222);
      repeat (10) @(negedge clk);
      check(acc_cnt[0] == 0, "R10 R7 no pair after mode change", 48'(acc_cnt[0]), 48'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule